// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block sits beside a small 8-bit processor core and takes over the core for the few cycles needed to enter or leave an interrupt service routine. Five request flags arrive, each gated by its own enable bit and by one global enable. When a qualified request is seen while the block is idle, it selects the source, stalls the core, and saves the 16-bit program counter into the internal data RAM. It saves it as two bytes through a stack pointer that is incremented before each write. It then hands the core the fixed entry address for that source.

When the core signals a return-from-interrupt, the block reads the two saved bytes back. It reads at the stack pointer and decrements the pointer after each read. It then reloads the core's program counter. After a return, no new request is taken until the core reports one completed instruction, so the interrupted program always makes progress between service routines. The stack pointer lives inside the block, starts at 07h, and is shared by nested entries, which unwind in last-in, first-out order.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the stack pointer is 07h, `ram_addr_o` shows the stack pointer whenever no RAM write is in progress, and `busy_o`, `ram_we_o`, `ram_re_o`, `pc_load_o` and `ack_o` are all low.
- R2: A source is taken only when its request bit, its enable bit and `gen_i` are all 1 in the same cycle while the block is idle; a masked request causes no RAM write and no program-counter load.
- R3: Source index i (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial) has the entry address 0003h + 8*i. Among qualified requests the lowest index wins. `ack_o` carries the one-hot bit of the winner during the first save cycle.
- R4: The cycle after a request is taken, the block writes PC[7:0] at SP+1. The next cycle it writes PC[15:8] at SP+2, and the stack pointer ends two higher.
- R5: In the cycle after the second write, `pc_load_o` is 1 for one cycle with `pc_o` equal to the entry address. `busy_o` is high from the first save cycle through that load cycle and low the cycle after.
- R6: One cycle after `reti_i` is seen in the idle state, the block reads at SP and then, in the next cycle, at SP-1. The RAM returns read data one cycle after the read. The first byte read is PC[15:8] and the second is PC[7:0]. Two cycles after the last read, `pc_o` holds the restored value with `pc_load_o` high for one cycle, and the stack pointer ends two lower.
- R7: No request is accepted while a save or restore sequence runs. After a return, no request is accepted until `insn_done_i` has been high on one clock edge.
- R8: An entry accepted inside a service routine saves at the next two stack locations, and two returns restore the inner and then the outer program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Request flags, bit i = source index i |
| en_i | input | 5 | Per-source enable bits |
| gen_i | input | 1 | Global enable |
| reti_i | input | 1 | Return-from-interrupt request from the core |
| insn_done_i | input | 1 | One core instruction completed |
| pc_i | input | 16 | Current program counter of the core |
| pc_load_o | output | 1 | Load `pc_o` into the core's program counter |
| pc_o | output | 16 | Entry address or restored program counter |
| ram_we_o | output | 1 | Data RAM write strobe |
| ram_re_o | output | 1 | Data RAM read strobe (data one cycle later) |
| ram_addr_o | output | 8 | Data RAM address |
| ram_wdata_o | output | 8 | Data RAM write byte |
| ram_rdata_i | input | 8 | Data RAM read byte |
| busy_o | output | 1 | Core stall while a sequence runs |
| ack_o | output | 5 | One-hot acknowledge of the source being entered |

## Verification
The entry path is tried with all five sources pending at once, drained one per service routine. This separates a correct priority order and entry-address table from a swapped or mis-scaled one. Requests masked by their own enable and by the global enable are mixed with a lower-priority enabled one, which tells the per-source gate apart from the global gate. Nested entries with distinct program-counter values show whether byte order and stack direction agree between save and restore. Holding a request pending right after a return shows whether the one-instruction guard is honoured.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PUSH_LO,
      ST_PUSH_HI,
      ST_VEC,
      ST_POP_HI,
      ST_POP_LO,
      ST_POP_WAIT,
      ST_RESUME,
      ST_GUARD
   } seq_state_e;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NSRC  = 5,
   parameter int SRC_W = 3
) (
   input  logic [NSRC-1:0]  pend_i,
   output logic             any_o,
   output logic [SRC_W-1:0] idx_o,
   output logic [NSRC-1:0]  grant_o
);

   // seen[g] is set when any lane below g is pending
   logic [NSRC:0] seen;
   assign seen[0] = 1'b0;

   for (genvar g = 0; g < NSRC; g++) begin : g_lane
      assign grant_o[g]  = pend_i[g] & ~seen[g];
      assign seen[g + 1] = seen[g] | pend_i[g];
   end

   assign any_o = seen[NSRC];

   always_comb begin
      idx_o = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend_i[i]) idx_o = SRC_W'(i);
      end
   end

endmodule

// File: rtl/irq_sp.sv
module irq_sp #(
   parameter int          SP_W   = 8,
   parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc_i,
   input  logic            dec_i,
   output logic [SP_W-1:0] sp_o,
   output logic [SP_W-1:0] sp_next_o
);

   logic [SP_W-1:0] sp_q;

   assign sp_next_o = sp_q + SP_W'(1);
   assign sp_o      = sp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= SP_RST;
      end else if (inc_i) begin
         sp_q <= sp_q + SP_W'(1);
      end else if (dec_i) begin
         sp_q <= sp_q - SP_W'(1);
      end
   end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import irq_entry_pkg::*;
#(
   parameter int NSRC       = 5,
   parameter int SRC_W      = 3,
   parameter int DW         = 8,
   parameter int PC_W       = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic [SRC_W-1:0] idx_i,
   input  logic [NSRC-1:0]  grant_i,
   input  logic             reti_i,
   input  logic             insn_done_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [DW-1:0]    ram_rdata_i,
   output logic             ram_we_o,
   output logic             ram_re_o,
   output logic [DW-1:0]    ram_wdata_o,
   output logic             pc_load_o,
   output logic [PC_W-1:0]  pc_o,
   output logic             busy_o,
   output logic [NSRC-1:0]  ack_o
);

   seq_state_e       state_q;
   logic [PC_W-1:0]  pc_save_q;
   logic [SRC_W-1:0] src_q;
   logic [NSRC-1:0]  grant_q;
   logic [DW-1:0]    hi_q;
   logic [DW-1:0]    lo_q;
   logic [PC_W-1:0]  vec_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pc_save_q <= '0;
         src_q     <= '0;
         grant_q   <= '0;
         hi_q      <= '0;
         lo_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (reti_i) begin
                  state_q <= ST_POP_HI;
               end else if (take_i) begin
                  pc_save_q <= pc_i;
                  src_q     <= idx_i;
                  grant_q   <= grant_i;
                  state_q   <= ST_PUSH_LO;
               end
            end
            ST_PUSH_LO:  state_q <= ST_PUSH_HI;
            ST_PUSH_HI:  state_q <= ST_VEC;
            ST_VEC:      state_q <= ST_IDLE;
            ST_POP_HI:   state_q <= ST_POP_LO;
            ST_POP_LO: begin
               hi_q    <= ram_rdata_i;
               state_q <= ST_POP_WAIT;
            end
            ST_POP_WAIT: begin
               lo_q    <= ram_rdata_i;
               state_q <= ST_RESUME;
            end
            ST_RESUME:   state_q <= ST_GUARD;
            ST_GUARD: begin
               if (insn_done_i) state_q <= ST_IDLE;
            end
            default:     state_q <= ST_IDLE;
         endcase
      end
   end

   assign vec_addr = PC_W'(VEC_BASE) + PC_W'(VEC_STRIDE) * PC_W'(src_q);

   always_comb begin
      ram_we_o    = 1'b0;
      ram_re_o    = 1'b0;
      ram_wdata_o = '0;
      pc_load_o   = 1'b0;
      pc_o        = '0;
      busy_o      = 1'b1;
      ack_o       = '0;
      unique case (state_q)
         ST_IDLE:  busy_o = 1'b0;
         ST_GUARD: busy_o = 1'b0;
         ST_PUSH_LO: begin
            ram_we_o    = 1'b1;
            ram_wdata_o = pc_save_q[DW-1:0];
            ack_o       = grant_q;
         end
         ST_PUSH_HI: begin
            ram_we_o    = 1'b1;
            ram_wdata_o = pc_save_q[PC_W-1:DW];
         end
         ST_VEC: begin
            pc_load_o = 1'b1;
            pc_o      = vec_addr;
         end
         ST_POP_HI, ST_POP_LO: ram_re_o = 1'b1;
         ST_RESUME: begin
            pc_load_o = 1'b1;
            pc_o      = {hi_q, lo_q};
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int NSRC       = 5,
   parameter int DW         = 8,
   parameter int PC_W       = 16,
   parameter int SP_W       = 8,
   parameter int SP_RST     = 7,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req_i,
   input  logic [NSRC-1:0] en_i,
   input  logic            gen_i,
   input  logic            reti_i,
   input  logic            insn_done_i,
   input  logic [PC_W-1:0] pc_i,
   output logic            pc_load_o,
   output logic [PC_W-1:0] pc_o,
   output logic            ram_we_o,
   output logic            ram_re_o,
   output logic [SP_W-1:0] ram_addr_o,
   output logic [DW-1:0]   ram_wdata_o,
   input  logic [DW-1:0]   ram_rdata_i,
   output logic            busy_o,
   output logic [NSRC-1:0] ack_o
);

   localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam longint LAST_VEC = longint'(VEC_BASE) + longint'(VEC_STRIDE) * longint'(NSRC - 1);

   if (PC_W != 2 * DW) begin : g_bad_pc_width
      $error("program counter must be exactly two RAM bytes wide");
   end
   if (NSRC < 2) begin : g_bad_nsrc
      $error("at least two sources are required");
   end
   if (LAST_VEC >= (longint'(1) << PC_W)) begin : g_bad_vec
      $error("entry addresses do not fit the program counter");
   end
   if (SP_RST >= (1 << SP_W)) begin : g_bad_sp
      $error("stack pointer reset value does not fit");
   end

   logic [NSRC-1:0]  pend;
   logic             any_pend;
   logic [SRC_W-1:0] win_idx;
   logic [NSRC-1:0]  win_grant;
   logic [SP_W-1:0]  sp_cur;
   logic [SP_W-1:0]  sp_up;

   assign pend = req_i & en_i;

   irq_pick #(
      .NSRC  (NSRC),
      .SRC_W (SRC_W)
   ) u_pick (
      .pend_i  (pend),
      .any_o   (any_pend),
      .idx_o   (win_idx),
      .grant_o (win_grant)
   );

   irq_sp #(
      .SP_W   (SP_W),
      .SP_RST (SP_W'(SP_RST))
   ) u_sp (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (ram_we_o),
      .dec_i     (ram_re_o),
      .sp_o      (sp_cur),
      .sp_next_o (sp_up)
   );

   irq_ctrl #(
      .NSRC       (NSRC),
      .SRC_W      (SRC_W),
      .DW         (DW),
      .PC_W       (PC_W),
      .VEC_BASE   (VEC_BASE),
      .VEC_STRIDE (VEC_STRIDE)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_i      (any_pend & gen_i),
      .idx_i       (win_idx),
      .grant_i     (win_grant),
      .reti_i      (reti_i),
      .insn_done_i (insn_done_i),
      .pc_i        (pc_i),
      .ram_rdata_i (ram_rdata_i),
      .ram_we_o    (ram_we_o),
      .ram_re_o    (ram_re_o),
      .ram_wdata_o (ram_wdata_o),
      .pc_load_o   (pc_load_o),
      .pc_o        (pc_o),
      .busy_o      (busy_o),
      .ack_o       (ack_o)
   );

   // pre-increment on save, address at SP on restore
   assign ram_addr_o = ram_we_o ? sp_up : sp_cur;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int NSRC = 5,
   parameter int SP_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            gen_i,
   input logic            ram_we_o,
   input logic            ram_re_o,
   input logic [SP_W-1:0] ram_addr_o,
   input logic            pc_load_o,
   input logic            busy_o,
   input logic [NSRC-1:0] ack_o
);

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy_o && !ram_we_o && !ram_re_o && !pc_load_o));

   p_masked_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !gen_i) |=> !ram_we_o);

   p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o));

   p_ack_with_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o != '0) |-> ram_we_o);

   p_push_ascends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we_o && $past(ram_we_o)) |-> (ram_addr_o == $past(ram_addr_o) + SP_W'(1)));

   p_ram_access_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we_o || ram_re_o) |-> busy_o);

   p_rw_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we_o && ram_re_o));

   p_vector_follows_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_o) |-> pc_load_o);

   p_pop_descends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_re_o && $past(ram_re_o)) |-> (ram_addr_o == $past(ram_addr_o) - SP_W'(1)));

   p_guard_after_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && !$past(ram_we_o)) |=> !ram_we_o);

endmodule

bind irq_entry_seq irq_entry_chk #(
   .NSRC (NSRC),
   .SP_W (SP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gen_i      (gen_i),
   .ram_we_o   (ram_we_o),
   .ram_re_o   (ram_re_o),
   .ram_addr_o (ram_addr_o),
   .pc_load_o  (pc_load_o),
   .busy_o     (busy_o),
   .ack_o      (ack_o)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  req_i = '0;
   logic [4:0]  en_i = '0;
   logic        gen_i = 1'b0;
   logic        reti_i = 1'b0;
   logic        insn_done_i = 1'b0;
   logic [15:0] pc_i = '0;
   logic        pc_load_o;
   logic [15:0] pc_o;
   logic        ram_we_o;
   logic        ram_re_o;
   logic [7:0]  ram_addr_o;
   logic [7:0]  ram_wdata_o;
   logic [7:0]  ram_rdata_i = '0;
   logic        busy_o;
   logic [4:0]  ack_o;

   logic [7:0]  mem [256];

   int n_checks = 0;
   int n_errors = 0;
   int exp_sp   = 7;
   bit done     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_entry_seq dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .en_i        (en_i),
      .gen_i       (gen_i),
      .reti_i      (reti_i),
      .insn_done_i (insn_done_i),
      .pc_i        (pc_i),
      .pc_load_o   (pc_load_o),
      .pc_o        (pc_o),
      .ram_we_o    (ram_we_o),
      .ram_re_o    (ram_re_o),
      .ram_addr_o  (ram_addr_o),
      .ram_wdata_o (ram_wdata_o),
      .ram_rdata_i (ram_rdata_i),
      .busy_o      (busy_o),
      .ack_o       (ack_o)
   );

   // data RAM model with one cycle of read latency
   always @(posedge clk) begin
      if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
      if (ram_re_o) ram_rdata_i <= mem[ram_addr_o];
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic no_write_for(input int cycles, input string req);
      for (int k = 0; k < cycles; k++) begin
         tick();
         check(!ram_we_o && !pc_load_o, req, "no entry while blocked",
               {ram_we_o, pc_load_o}, 0);
      end
   endtask

   // R3 R4 R5: one full entry; requests already applied by the caller
   task automatic do_take(input int src, input logic [15:0] pc);
      logic [15:0] vec;
      vec  = 16'(3 + 8 * src);
      pc_i = pc;
      tick();
      check(ram_we_o && ram_addr_o == 8'(exp_sp + 1), "R4", "low byte address",
            ram_addr_o, exp_sp + 1);
      check(ram_wdata_o == pc[7:0], "R4", "low byte data", ram_wdata_o, pc[7:0]);
      check(ack_o == 5'(1 << src), "R3", "acknowledge", ack_o, 1 << src);
      check(busy_o, "R5", "busy in first save", busy_o, 1);
      req_i[src] = 1'b0;
      tick();
      check(ram_we_o && ram_addr_o == 8'(exp_sp + 2), "R4", "high byte address",
            ram_addr_o, exp_sp + 2);
      check(ram_wdata_o == pc[15:8], "R4", "high byte data", ram_wdata_o, pc[15:8]);
      tick();
      check(pc_load_o && !ram_we_o, "R5", "vector load strobe", pc_load_o, 1);
      check(pc_o == vec, "R3", "entry address", pc_o, vec);
      check(busy_o, "R5", "busy in vector cycle", busy_o, 1);
      exp_sp += 2;
      tick();
      check(!busy_o && !pc_load_o, "R5", "busy released", busy_o, 0);
   endtask

   // R6: full return sequence
   task automatic do_reti(input logic [15:0] pc);
      reti_i = 1'b1;
      tick();
      reti_i = 1'b0;
      check(ram_re_o && ram_addr_o == 8'(exp_sp), "R6", "first read address",
            ram_addr_o, exp_sp);
      check(busy_o, "R6", "busy during restore", busy_o, 1);
      tick();
      check(ram_re_o && ram_addr_o == 8'(exp_sp - 1), "R6", "second read address",
            ram_addr_o, exp_sp - 1);
      tick();
      check(!ram_re_o && !pc_load_o, "R6", "latency cycle", {ram_re_o, pc_load_o}, 0);
      tick();
      check(pc_load_o && pc_o == pc, "R6", "restored program counter", pc_o, pc);
      exp_sp -= 2;
      tick();
      check(!busy_o && !pc_load_o, "R6", "restore finished", busy_o, 0);
   endtask

   task automatic do_insn();
      insn_done_i = 1'b1;
      tick();
      insn_done_i = 1'b0;
   endtask

   task automatic t_reset();
      check(!busy_o && !ram_we_o && !ram_re_o && !pc_load_o && ack_o == 0, "R1",
            "idle outputs", {busy_o, ram_we_o, ram_re_o, pc_load_o}, 0);
      check(ram_addr_o == 8'h07, "R1", "stack pointer at reset", ram_addr_o, 8'h07);
   endtask

   task automatic t_masking();
      gen_i = 1'b1;
      en_i  = 5'b11011;
      req_i = 5'b00100;
      no_write_for(3, "R2");
      en_i  = 5'b11111;
      gen_i = 1'b0;
      no_write_for(3, "R2");
      gen_i = 1'b1;
      do_take(2, 16'h1234);
      do_reti(16'h1234);
      do_insn();
      // a higher-priority request masked by its enable leaves timer 0 to win
      req_i = 5'b00011;
      en_i  = 5'b00010;
      do_take(1, 16'h2468);
      req_i = '0;
      en_i  = 5'b11111;
      do_reti(16'h2468);
      do_insn();
   endtask

   task automatic t_priority();
      req_i = 5'b11111;
      en_i  = 5'b11111;
      gen_i = 1'b1;
      for (int i = 0; i < 5; i++) begin
         logic [15:0] pc;
         pc = 16'h1000 + 16'(i) * 16'h0111;
         do_take(i, pc);
         do_reti(pc);
         if (i < 4) no_write_for(3, "R7");
         do_insn();
      end
   endtask

   task automatic t_nesting();
      req_i = 5'b00100;
      do_take(2, 16'h4567);
      req_i = 5'b00001;
      do_take(0, 16'h89AB);
      check(exp_sp == 11, "R8", "stack depth after two entries", exp_sp, 11);
      do_reti(16'h89AB);
      do_insn();
      do_reti(16'h4567);
      do_insn();
      tick();
      check(ram_addr_o == 8'h07, "R8", "stack pointer unwound", ram_addr_o, 8'h07);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_masking();
      t_priority();
      t_nesting();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule